// File: doc/BRIEF.md
# Two-Wire Register Bridge Slave with Selectable Completion Signalling

This block is a 2-wire serial slave that turns register writes and reads from a host into single accesses on a slower back-end port. The back-end answers after a delay that the slave cannot bound, because it includes a link transfer and a remote access. The slave therefore tells the host when the access has finished, in one of two ways chosen by a single input, `stretch_en`.

When `stretch_en` is high, the slave holds SCL low after the acknowledge that launched the access. It lets SCL go only when the back-end reports done. A read then returns its fresh data in the same transaction. When `stretch_en` is low, the bus is never held. The host carries on at full speed, and a level interrupt `irq` rises once the back-end completes. The interrupt stays up until software pulses `irq_clr`.

Both bus lines are open drain. Each is seen as a sampled input (`scl_i`, `sda_i`) plus a drive-low enable (`scl_oe`, `sda_oe`). The inputs are synchronised into the system clock domain. Start and Stop conditions are recognised as SDA edges that occur while SCL is high.

Top module: `i2cb_bridge`

## Requirements
- R1: The first byte after a Start is acknowledged (SDA pulled low during the ninth clock) only when its bits 7:1 equal DEV_ADDR. Any other address is not acknowledged, issues no request, and leaves SDA undriven until the next Start.
- R2: A write is a Start, then an address byte with bit 0 = 0, then a register byte, then a data byte. When the acknowledge clock of the data byte ends, be_req pulses for one cycle with be_we=1, be_addr = the register byte and be_wdata = the data byte. These three hold their values until be_done.
- R3: When stretch_en=1 at launch, scl_oe is high from the SCL falling edge that ends the launching acknowledge until the cycle after be_done. Any completion delay is accepted.
- R4: A read is a register-select write (Start, address byte with bit 0 = 0, register byte, Stop), followed by a Start and an address byte with bit 0 = 1. After that byte's acknowledge, a request with be_we=0 and be_addr = the selected register is issued. In stretch mode, the byte then sent is the be_rdata of that access, MSB first, with a new bit after each SCL falling edge.
- R5: When stretch_en=0 at launch, the slave never pulls SCL low.
- R6: irq rises one cycle after be_done of an access launched with stretch_en=0. It stays high until irq_clr is high at a clock edge. A completion at the same edge as irq_clr leaves irq high.
- R7: While an access is outstanding, a data byte that would launch a write and an address byte with bit 0 = 1 are both not acknowledged, and neither issues a request.
- R8: When stretch_en=0, a read returns the data of the most recently completed read access. The access it launches completes later.
- R9: An access launched with stretch_en=1 never raises irq.
- R10: After reset, scl_oe, sda_oe, be_req and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stretch_en | input | 1 | 1: hold SCL until completion; 0: signal completion on irq |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| be_req | output | 1 | One-cycle back-end access request |
| be_we | output | 1 | Access direction, 1 = write |
| be_addr | output | 8 | Register address of the access |
| be_wdata | output | 8 | Write data of the access |
| be_done | input | 1 | One-cycle completion pulse from the back-end |
| be_rdata | input | 8 | Read data, valid with be_done |
| irq | output | 1 | Level completion interrupt |
| irq_clr | input | 1 | Clears irq |

## Verification
The assertions assume the back-end behaves in a fixed way. It answers each request with exactly one be_done, it never pulses done with nothing outstanding, and its earliest done comes two cycles after be_req. They also assume the host master honours a held clock: it releases SCL and waits until the line really reads high. Outside Start and Stop, the master moves SDA only while SCL is low. The bench master keeps within these assumptions. It uses a quarter bit time of four clocks, which is longer than the synchroniser and edge-detection delay, and it waits on the wired SCL level after every release. The bench responder returns exactly one done per request after a programmed latency, reaching into the thousands of cycles.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // Link engine state
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_HOLD,
        LS_TX,
        LS_MACK
    } link_st_e;

    // Position of a received byte within a transaction
    typedef enum logic [1:0] {
        BP_DEV,
        BP_REG,
        BP_DATA,
        BP_EXTRA
    } byte_pos_e;

    // Synchronised bus events
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Back-end command
    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } be_cmd_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic byte_pos_e next_pos(input byte_pos_e p);
        case (p)
            BP_DEV:  return BP_REG;
            BP_REG:  return BP_DATA;
            default: return BP_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/i2cb_sync.sv
`timescale 1ns/1ps
module i2cb_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], d[i]};
        end
        assign q[i] = ff[STAGES-1];
    end

endmodule

// File: rtl/i2cb_events.sv
`timescale 1ns/1ps
module i2cb_events import i2cb_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.sda      = sda;
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
    end

endmodule

// File: rtl/i2cb_link.sv
`timescale 1ns/1ps
module i2cb_link import i2cb_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              stretch_en,
    input  logic              pending,
    input  logic              be_done,
    input  logic [BYTE_W-1:0] be_rdata,
    input  logic [BYTE_W-1:0] rdbuf,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              be_req,
    output be_cmd_t           cmd
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    link_st_e          st;
    byte_pos_e         pos;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh, tx, regaddr, wdata;
    logic              rw, launch_q, mack;
    logic              ack_ok, launch_c;

    // Acknowledge and launch decision for the byte just received
    always_comb begin
        ack_ok   = 1'b0;
        launch_c = 1'b0;
        case (pos)
            BP_DEV: begin
                ack_ok   = addr_hit(sh, DEV_ADDR) && !(sh[0] && pending);
                launch_c = sh[0];
            end
            BP_REG:  ack_ok = 1'b1;
            BP_DATA: begin
                ack_ok   = !pending;
                launch_c = 1'b1;
            end
            default: ack_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LS_IDLE;
            pos      <= BP_DEV;
            bitcnt   <= '0;
            sh       <= '0;
            tx       <= '0;
            regaddr  <= '0;
            wdata    <= '0;
            rw       <= 1'b0;
            launch_q <= 1'b0;
            mack     <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            be_req   <= 1'b0;
            cmd      <= '0;
        end else begin
            be_req <= 1'b0;
            if (ev.start) begin
                st     <= LS_RX;
                pos    <= BP_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    LS_RX: begin
                        if (ev.scl_rise && bitcnt != FULL) begin
                            sh     <= {sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == FULL) begin
                            bitcnt <= '0;
                            pos    <= next_pos(pos);
                            if (pos == BP_DEV)  rw      <= sh[0];
                            if (pos == BP_REG)  regaddr <= sh;
                            if (pos == BP_DATA) wdata   <= sh;
                            if (ack_ok) begin
                                sda_oe   <= 1'b1;
                                launch_q <= launch_c;
                                st       <= LS_ACK;
                            end else begin
                                st <= LS_IDLE;
                            end
                        end
                    end
                    LS_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            if (launch_q) begin
                                be_req    <= 1'b1;
                                cmd.we    <= ~rw;
                                cmd.addr  <= regaddr;
                                cmd.wdata <= wdata;
                            end
                            if (launch_q && stretch_en) begin
                                scl_oe <= 1'b1;
                                st     <= LS_HOLD;
                            end else if (rw) begin
                                tx     <= rdbuf;
                                sda_oe <= ~rdbuf[BYTE_W-1];
                                bitcnt <= '0;
                                st     <= LS_TX;
                            end else begin
                                st <= LS_RX;
                            end
                        end
                    end
                    LS_HOLD: begin
                        if (be_done) begin
                            scl_oe <= 1'b0;
                            if (rw) begin
                                tx     <= be_rdata;
                                sda_oe <= ~be_rdata[BYTE_W-1];
                                bitcnt <= '0;
                                st     <= LS_TX;
                            end else begin
                                st <= LS_RX;
                            end
                        end
                    end
                    LS_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == LAST) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                st     <= LS_MACK;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    LS_MACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                tx     <= rdbuf;
                                sda_oe <= ~rdbuf[BYTE_W-1];
                                st     <= LS_TX;
                            end else begin
                                st <= LS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cb_cmpl.sv
`timescale 1ns/1ps
module i2cb_cmpl import i2cb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              be_req,
    input  logic              be_we,
    input  logic              held,
    input  logic              be_done,
    input  logic [BYTE_W-1:0] be_rdata,
    input  logic              irq_clr,
    output logic              pending,
    output logic              irq,
    output logic [BYTE_W-1:0] rdbuf
);

    logic held_q, rd_q, fin;

    assign fin = be_done && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held_q  <= 1'b0;
            rd_q    <= 1'b0;
            irq     <= 1'b0;
            rdbuf   <= '0;
        end else begin
            if (be_req) begin
                pending <= 1'b1;
                held_q  <= held;
                rd_q    <= ~be_we;
            end else if (fin) begin
                pending <= 1'b0;
            end
            if (fin && rd_q) rdbuf <= be_rdata;
            if (fin && !held_q)  irq <= 1'b1;
            else if (irq_clr)    irq <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cb_bridge.sv
`timescale 1ns/1ps
module i2cb_bridge import i2cb_pkg::*; #(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stretch_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              be_req,
    output logic              be_we,
    output logic [BYTE_W-1:0] be_addr,
    output logic [BYTE_W-1:0] be_wdata,
    input  logic              be_done,
    input  logic [BYTE_W-1:0] be_rdata,
    output logic              irq,
    input  logic              irq_clr
);

    logic [1:0]        lines;
    bus_ev_t           ev;
    be_cmd_t           cmd;
    logic              pending;
    logic [BYTE_W-1:0] rdbuf;

    i2cb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines)
    );

    i2cb_events u_ev (
        .clk (clk),
        .rst (rst),
        .scl (lines[1]),
        .sda (lines[0]),
        .ev  (ev)
    );

    i2cb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .stretch_en (stretch_en),
        .pending    (pending),
        .be_done    (be_done),
        .be_rdata   (be_rdata),
        .rdbuf      (rdbuf),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .be_req     (be_req),
        .cmd        (cmd)
    );

    i2cb_cmpl u_cmpl (
        .clk      (clk),
        .rst      (rst),
        .be_req   (be_req),
        .be_we    (cmd.we),
        .held     (scl_oe),
        .be_done  (be_done),
        .be_rdata (be_rdata),
        .irq_clr  (irq_clr),
        .pending  (pending),
        .irq      (irq),
        .rdbuf    (rdbuf)
    );

    assign be_we    = cmd.we;
    assign be_addr  = cmd.addr;
    assign be_wdata = cmd.wdata;

endmodule

// File: rtl/i2cb_bridge_chk.sv
`timescale 1ns/1ps
module i2cb_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_oe,
    input logic       be_req,
    input logic       be_we,
    input logic [7:0] be_addr,
    input logic [7:0] be_wdata,
    input logic       be_done,
    input logic       irq,
    input logic       irq_clr
);

    logic outst, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (be_req)       outst <= 1'b1;
            else if (be_done) outst <= 1'b0;
            if (be_req) hold_q <= scl_oe;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) be_req |=> !be_req); // R2
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (outst && !be_done) |=> ($stable(be_addr) && $stable(be_we) && $stable(be_wdata))); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) be_req |-> !outst); // R7
    AST_SCL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) scl_oe |-> (outst || be_req)); // R3
    AST_SCL_HELD: assert property (@(posedge clk) disable iff (rst)
        (outst && hold_q && !be_done) |-> scl_oe); // R3
    AST_SCL_FREE_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        (outst && !hold_q) |-> !scl_oe); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (irq && !irq_clr) |=> irq); // R6
    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(be_done)); // R6
    AST_NO_IRQ_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (be_done && outst && hold_q) |=> !$rose(irq)); // R9

endmodule

bind i2cb_bridge i2cb_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_oe   (scl_oe),
    .be_req   (be_req),
    .be_we    (be_we),
    .be_addr  (be_addr),
    .be_wdata (be_wdata),
    .be_done  (be_done),
    .irq      (irq),
    .irq_clr  (irq_clr)
);

// File: tb/i2cb_bridge_bench.sv
`timescale 1ns/1ps
module i2cb_bridge_bench;

    localparam logic [6:0] DEV = 7'h2C;
    localparam int         Q   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stretch_en = 1'b1;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe;
    logic       be_req, be_we, be_done;
    logic [7:0] be_addr, be_wdata, be_rdata;
    logic       irq, tb_clr, rsp_clr, irq_clr;

    int checks = 0;
    int errors = 0;

    // responder state
    int         lat = 10;
    int         cnt = 0;
    bit         busy = 1'b0;
    bit         clr_on_done = 1'b0;
    int         req_cnt = 0;
    int         done_cnt = 0;
    int         unstable = 0;
    logic       cap_we;
    logic [7:0] cap_addr, cap_wdata;

    // bus observation
    int scl_drv = 0;
    int max_stretch = 0;

    always #10 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);
    assign irq_clr  = tb_clr | rsp_clr;

    i2cb_bridge #(.DEV_ADDR(DEV)) u_i2cb_bridge (
        .clk        (clk),
        .rst        (rst),
        .stretch_en (stretch_en),
        .scl_i      (scl_line),
        .sda_i      (sda_line),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .be_req     (be_req),
        .be_we      (be_we),
        .be_addr    (be_addr),
        .be_wdata   (be_wdata),
        .be_done    (be_done),
        .be_rdata   (be_rdata),
        .irq        (irq),
        .irq_clr    (irq_clr)
    );

    // Variable-latency back-end responder
    always @(posedge clk) begin
        be_done <= 1'b0;
        rsp_clr <= 1'b0;
        if (rst) begin
            busy     <= 1'b0;
            be_rdata <= 8'h00;
        end else if (be_req) begin
            busy      <= 1'b1;
            cnt       <= lat;
            cap_we    <= be_we;
            cap_addr  <= be_addr;
            cap_wdata <= be_wdata;
            req_cnt   <= req_cnt + 1;
        end else if (busy) begin
            if (be_addr != cap_addr || be_we != cap_we || be_wdata != cap_wdata)
                unstable <= unstable + 1;
            if (cnt == 0) begin
                be_done  <= 1'b1;
                be_rdata <= cap_addr ^ 8'hA5;
                rsp_clr  <= clr_on_done;
                busy     <= 1'b0;
                done_cnt <= done_cnt + 1;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    always @(negedge clk) if (scl_oe) scl_drv <= scl_drv + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_scl();
        int s;
        s = 0;
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) begin
            @(negedge clk);
            s++;
        end
        if (s > max_stretch) max_stretch = s;
    endtask

    task automatic m_start();
        max_stretch = 0;
        m_sda_low = 1'b0;
        m_scl_low = 1'b0;
        wait_clk(Q);
        m_sda_low = 1'b1;
        wait_clk(Q);
        m_scl_low = 1'b1;
        wait_clk(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        wait_clk(Q);
        release_scl();
        wait_clk(Q);
        m_sda_low = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bit_wr(input bit b);
        m_sda_low = !b;
        wait_clk(Q);
        release_scl();
        wait_clk(2 * Q);
        m_scl_low = 1'b1;
        wait_clk(Q);
    endtask

    task automatic bit_rd(output bit b);
        m_sda_low = 1'b0;
        wait_clk(Q);
        release_scl();
        wait_clk(Q);
        b = sda_line;
        wait_clk(Q);
        m_scl_low = 1'b1;
        wait_clk(Q);
    endtask

    task automatic byte_wr(input logic [7:0] v, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) bit_wr(v[i]);
        bit_rd(a);
        acked = !a;
    endtask

    task automatic byte_rd(output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            bit_rd(b);
            v[i] = b;
        end
        bit_wr(1'b1);
    endtask

    task automatic do_write(input logic [6:0] a7, input logic [7:0] r, input logic [7:0] d,
                            output bit aa, output bit ra, output bit da);
        ra = 1'b0;
        da = 1'b0;
        m_start();
        byte_wr({a7, 1'b0}, aa);
        if (aa) begin
            byte_wr(r, ra);
            byte_wr(d, da);
        end
        m_stop();
    endtask

    task automatic do_read(input logic [6:0] a7, input logic [7:0] r, output bit aa, output logic [7:0] d);
        bit x;
        d = 8'h00;
        m_start();
        byte_wr({a7, 1'b0}, x);
        byte_wr(r, x);
        m_stop();
        m_start();
        byte_wr({a7, 1'b1}, aa);
        if (aa) byte_rd(d);
        m_stop();
    endtask

    task automatic wait_irq(input int lim, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
    endtask

    task automatic clear_irq();
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10", "line drives after reset", {scl_oe, sda_oe}, 0);
        chk(be_req == 1'b0, "R10", "be_req after reset", be_req, 0);
        chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
    endtask

    task automatic t_addr_miss();
        bit aa, ra, da;
        int r0;
        stretch_en = 1'b1;
        r0 = req_cnt;
        do_write(7'h13, 8'h01, 8'h02, aa, ra, da);
        wait_clk(10);
        chk(aa == 1'b0, "R1", "foreign address acknowledged", aa, 0);
        chk(req_cnt == r0, "R1", "request count after foreign address", req_cnt, r0);
    endtask

    task automatic t_stretch_write();
        bit aa, ra, da;
        int r0;
        stretch_en = 1'b1;
        lat = 60;
        r0 = req_cnt;
        do_write(DEV, 8'h3C, 8'h9E, aa, ra, da);
        wait_clk(10);
        chk(aa && ra && da, "R1", "own-address write acks", {aa, ra, da}, 3'b111);
        chk(req_cnt == r0 + 1, "R2", "one write request", req_cnt, r0 + 1);
        chk(cap_we == 1'b1 && cap_addr == 8'h3C && cap_wdata == 8'h9E, "R2", "write command",
            {cap_we, cap_addr, cap_wdata}, {1'b1, 8'h3C, 8'h9E});
        chk(unstable == 0, "R2", "command held until done", unstable, 0);
        chk(max_stretch >= lat - 12 && max_stretch <= lat + 12, "R3", "stretch length", max_stretch, lat);
        chk(irq == 1'b0, "R9", "irq after stretched write", irq, 0);
    endtask

    task automatic t_stretch_read();
        bit aa;
        logic [7:0] d;
        stretch_en = 1'b1;
        lat = 100;
        do_read(DEV, 8'h47, aa, d);
        wait_clk(10);
        chk(aa, "R4", "read address ack", aa, 1);
        chk(cap_we == 1'b0 && cap_addr == 8'h47, "R4", "read command", {cap_we, cap_addr}, {1'b0, 8'h47});
        chk(d == 8'hE2, "R4", "stretched read data MSB first", d, 8'hE2);
        chk(max_stretch >= lat - 12, "R3", "read stretch length", max_stretch, lat);
        chk(irq == 1'b0, "R9", "irq after stretched read", irq, 0);
    endtask

    task automatic t_int_write();
        bit aa, ra, da, seen;
        int s0, r0;
        stretch_en = 1'b0;
        lat = 80;
        s0 = scl_drv;
        r0 = req_cnt;
        do_write(DEV, 8'h5A, 8'h33, aa, ra, da);
        chk(max_stretch == 0, "R5", "no stretch in irq mode", max_stretch, 0);
        chk(req_cnt == r0 + 1 && cap_addr == 8'h5A && cap_wdata == 8'h33, "R2", "irq-mode write command",
            {cap_addr, cap_wdata}, {8'h5A, 8'h33});
        wait_irq(500, seen);
        chk(seen, "R6", "irq raised on completion", seen, 1);
        wait_clk(20);
        chk(irq == 1'b1, "R6", "irq held without clear", irq, 1);
        chk(scl_drv == s0, "R5", "scl never driven in irq mode", scl_drv - s0, 0);
        clear_irq();
        chk(irq == 1'b0, "R6", "irq cleared", irq, 0);
    endtask

    task automatic t_int_busy();
        bit aa, ra, da, seen;
        logic [7:0] d;
        int r0;
        stretch_en = 1'b0;
        lat = 3000;
        do_write(DEV, 8'h10, 8'h11, aa, ra, da);
        chk(da, "R2", "first irq-mode write acked", da, 1);
        r0 = req_cnt;
        do_write(DEV, 8'h12, 8'h13, aa, ra, da);
        chk(aa && ra && !da, "R7", "write data refused while busy", {aa, ra, da}, 3'b110);
        do_read(DEV, 8'h14, aa, d);
        chk(!aa, "R7", "read address refused while busy", aa, 0);
        chk(req_cnt == r0, "R7", "no request while busy", req_cnt, r0);
        wait_irq(4000, seen);
        chk(seen, "R6", "irq after long access", seen, 1);
        clear_irq();
    endtask

    task automatic t_int_read();
        bit aa, seen;
        logic [7:0] d;
        stretch_en = 1'b0;
        lat = 40;
        do_read(DEV, 8'h21, aa, d);
        chk(aa && d == 8'hE2, "R8", "irq-mode read returns earlier data", d, 8'hE2);
        wait_irq(500, seen);
        clear_irq();
        do_read(DEV, 8'h05, aa, d);
        chk(d == 8'h84, "R8", "irq-mode read returns last completed read", d, 8'h84);
        wait_irq(500, seen);
        chk(seen && cap_addr == 8'h05, "R8", "second read launched", cap_addr, 8'h05);
        clear_irq();
    endtask

    task automatic t_clr_collide();
        bit aa, ra, da, seen;
        int d0;
        stretch_en = 1'b0;
        lat = 30;
        do_write(DEV, 8'h61, 8'h62, aa, ra, da);
        wait_irq(500, seen);
        chk(seen, "R6", "irq before collision", seen, 1);
        clr_on_done = 1'b1;
        d0 = done_cnt;
        do_write(DEV, 8'h63, 8'h64, aa, ra, da);
        for (int i = 0; i < 500 && done_cnt == d0; i++) @(negedge clk);
        clr_on_done = 1'b0;
        wait_clk(2);
        chk(irq == 1'b1, "R6", "completion wins over clear", irq, 1);
        clear_irq();
        chk(irq == 1'b0, "R6", "irq cleared after collision", irq, 0);
    endtask

    initial begin
        tb_clr = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_addr_miss();
        t_stretch_write();
        t_stretch_read();
        t_int_write();
        t_int_busy();
        t_int_read();
        t_clr_collide();
        wait_clk(10);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run incomplete, actual %0d expected %0d cycles max", 150000, 150000);
        report();
    end

endmodule